// File: doc/BRIEF.md
# Tagged DMA Command Queue

This block collects DMA transfer requests from a local processor, holds up to sixteen of them, and hands them one at a time to a transfer engine. Each request names a local-storage address, a global-memory address, a byte count, a 5-bit tag, a direction and an ordering modifier. A request is screened when it arrives. A request with an illegal size, a misaligned address or a reserved modifier is refused with an error pulse and never takes a slot.

Stored requests leave through the issue port in an order set by their tags. Requests with different tags never hold each other back. Within one tag, a fenced request waits until every older request with that tag has completed. A barrier request waits the same way, and it also holds back every younger request with its tag until the barrier itself has been issued. Among all requests that may go, the oldest one is offered first. The engine later reports completion by slot index. The slot is freed in that same cycle and the tag of the finished request is reported.

Top module: `dmaq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, push_ready is 1, and issue_valid, done_valid and push_err are 0.
- R2: A request is accepted only if all of these hold: the size is 1, 2, 4 or 8, or a nonzero multiple of 16 not above 16384; both addresses are aligned to the size, or to 16 when the size is a multiple of 16; and push_ord is not 3. A refused request raises push_err for exactly the cycle after its handshake, and it is never issued.
- R3: push_ready is 0 exactly when all 16 slots hold a request that has been accepted and not yet completed.
- R4: A request with push_ord 0 (no ordering) may issue unless an older request with the same tag is a barrier that has not yet issued. Requests with different tags never block each other.
- R5: A request with push_ord 1 (fence) may not issue while any older request with the same tag is waiting or in flight.
- R6: A request with push_ord 2 (barrier) obeys the fence rule, and every younger request with its tag waits until the barrier has issued.
- R7: When requests are eligible, issue_valid is 1 and the port carries the oldest eligible request's tag, addresses and size, with issue_id naming its slot. At most one request issues per cycle.
- R8: A completion with cpl_valid=1 on a slot that is in flight frees that slot in the same cycle, with done_valid=1 and done_tag set to the request's tag. A completion naming a slot that is not in flight has no effect.
- R9: A request transfers only when issue_valid and issue_ready are both 1. While issue_ready is 0, an offered request keeps being offered unless an older request becomes eligible.
- R10: Direction is carried unchanged from push_dir to issue_dir: 0 means get (global to local), 1 means put (local to global).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Request present |
| push_ready | output | 1 | A slot is free |
| push_laddr | input | 18 | Local-storage byte address |
| push_gaddr | input | 32 | Global-memory byte address |
| push_size | input | 15 | Transfer length in bytes |
| push_tag | input | 5 | Tag group |
| push_dir | input | 1 | 0 get, 1 put |
| push_ord | input | 2 | 0 none, 1 fence, 2 barrier, 3 reserved |
| push_err | output | 1 | Previous-cycle request was refused |
| issue_valid | output | 1 | A request is offered to the engine |
| issue_ready | input | 1 | Engine takes the offered request |
| issue_id | output | 4 | Slot of the offered request |
| issue_laddr | output | 18 | Local address of the offered request |
| issue_gaddr | output | 32 | Global address of the offered request |
| issue_size | output | 15 | Size of the offered request |
| issue_tag | output | 5 | Tag of the offered request |
| issue_dir | output | 1 | Direction of the offered request |
| cpl_valid | input | 1 | Engine reports a finished transfer |
| cpl_id | input | 4 | Slot of the finished transfer |
| done_valid | output | 1 | Completion was accepted, slot freed |
| done_tag | output | 5 | Tag of the completed request |

## Verification
A corrupted age order or slot state shows at the issue port in the very cycle that follows it. The wrong request is offered, or a request that is blocked by a fence or barrier is released, or an eligible request is held back. The bench therefore compares the offered request with its own ordered model in every cycle. A slot that leaks or is freed twice shows up later through push_ready when the queue fills, or through a completion that is wrongly accepted or wrongly ignored. Fill phases and stray completions are placed so that these errors surface within a few dozen cycles.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_BUSY = 2'd2
  } slot_e;

  localparam logic [1:0] ORD_NONE    = 2'd0;
  localparam logic [1:0] ORD_FENCE   = 2'd1;
  localparam logic [1:0] ORD_BARRIER = 2'd2;
  localparam logic [1:0] ORD_RSVD    = 2'd3;

endpackage

// File: rtl/dmaq_prio.sv
module dmaq_prio #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dmaq_check.sv
module dmaq_check
  import dmaq_pkg::*;
#(
  parameter int LADDR_W   = 18,
  parameter int GADDR_W   = 32,
  parameter int SIZE_W    = 15,
  parameter int MAX_BYTES = 16384,
  parameter int LINE_LOG2 = 4
) (
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic [GADDR_W-1:0] gaddr_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [1:0]         ord_i,
  output logic               ok_o
);

  localparam int LINE = 1 << LINE_LOG2;

  logic                 small_ok;
  logic                 block_ok;
  logic [LINE_LOG2-1:0] align_mask;
  logic                 aligned;

  // short transfers: single power of two below one line
  assign small_ok = $onehot(size_i) && (size_i < SIZE_W'(LINE)) && (size_i <= SIZE_W'(8));
  // long transfers: whole lines up to the cap
  assign block_ok = (size_i[LINE_LOG2-1:0] == '0) && (size_i != '0)
                    && (size_i <= SIZE_W'(MAX_BYTES));

  assign align_mask = small_ok ? (size_i[LINE_LOG2-1:0] - 1'b1) : '1;
  assign aligned    = ((laddr_i[LINE_LOG2-1:0] | gaddr_i[LINE_LOG2-1:0]) & align_mask) == '0;

  assign ok_o = (small_ok || block_ok) && aligned && (ord_i != ORD_RSVD);

endmodule

// File: rtl/dmaq_sched.sv
module dmaq_sched
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAG_W = 5,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic [IDX_W-1:0] alloc_idx_i,
  input  logic [DEPTH-1:0] wait_i,
  input  logic [DEPTH-1:0] busy_i,
  input  logic [TAG_W-1:0] tag_i [DEPTH],
  input  logic [1:0]       ord_i [DEPTH],
  output logic             pick_valid_o,
  output logic [IDX_W-1:0] pick_idx_o
);

  // older_q[i][j] set: slot j entered before slot i
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] older_d [DEPTH];
  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] elig;
  logic [DEPTH-1:0] sel;

  assign occ = wait_i | busy_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic any_same;
    logic bar_same;

    always_comb begin
      any_same = 1'b0;
      bar_same = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (older_q[i][j] && (tag_i[j] == tag_i[i])) begin
          if (occ[j]) any_same = 1'b1;
          if (wait_i[j] && (ord_i[j] == ORD_BARRIER)) bar_same = 1'b1;
        end
      end
    end

    assign elig[i] = wait_i[i] & ~bar_same & ((ord_i[i] == ORD_NONE) | ~any_same);
    assign sel[i]  = elig[i] & ~(|(older_q[i] & elig));
  end

  dmaq_prio #(.N(DEPTH), .IDX_W(IDX_W)) u_pick (
    .req_i   (sel),
    .found_o (pick_valid_o),
    .idx_o   (pick_idx_o)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) older_d[i] = older_q[i];
    if (alloc_i) begin
      for (int j = 0; j < DEPTH; j++) older_d[alloc_idx_i][j] = occ[j];
      for (int j = 0; j < DEPTH; j++) older_d[j][alloc_idx_i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else if (alloc_i) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= older_d[i];
    end
  end

  // any two live slots have exactly one age relation
  for (genvar a = 0; a < DEPTH; a++) begin : g_age_a
    for (genvar b = a + 1; b < DEPTH; b++) begin : g_age_b
      assert_age_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ[a] && occ[b]) |-> (older_q[a][b] != older_q[b][a]));
    end
  end

endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
  import dmaq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TAG_W     = 5,
  parameter int LADDR_W   = 18,
  parameter int GADDR_W   = 32,
  parameter int SIZE_W    = 15,
  parameter int MAX_BYTES = 16384,
  parameter int IDX_W     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  output logic               push_ready,
  input  logic [LADDR_W-1:0] push_laddr,
  input  logic [GADDR_W-1:0] push_gaddr,
  input  logic [SIZE_W-1:0]  push_size,
  input  logic [TAG_W-1:0]   push_tag,
  input  logic               push_dir,
  input  logic [1:0]         push_ord,
  output logic               push_err,
  output logic               issue_valid,
  input  logic               issue_ready,
  output logic [IDX_W-1:0]   issue_id,
  output logic [LADDR_W-1:0] issue_laddr,
  output logic [GADDR_W-1:0] issue_gaddr,
  output logic [SIZE_W-1:0]  issue_size,
  output logic [TAG_W-1:0]   issue_tag,
  output logic               issue_dir,
  input  logic               cpl_valid,
  input  logic [IDX_W-1:0]   cpl_id,
  output logic               done_valid,
  output logic [TAG_W-1:0]   done_tag
);

  slot_e              state_q [DEPTH];
  slot_e              state_d [DEPTH];
  logic [LADDR_W-1:0] laddr_q [DEPTH];
  logic [GADDR_W-1:0] gaddr_q [DEPTH];
  logic [SIZE_W-1:0]  size_q  [DEPTH];
  logic [TAG_W-1:0]   tag_q   [DEPTH];
  logic [1:0]         ord_q   [DEPTH];
  logic               dir_q   [DEPTH];
  logic               err_q;

  logic [DEPTH-1:0]   free_v, wait_v, busy_v, occ_v;
  logic               have_free;
  logic [IDX_W-1:0]   free_idx;
  logic               cmd_ok, push_acc, store;
  logic               pick_valid;
  logic [IDX_W-1:0]   pick_idx;
  logic               issue_fire, cpl_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_flags
    assign free_v[i] = (state_q[i] == SLOT_FREE);
    assign wait_v[i] = (state_q[i] == SLOT_WAIT);
    assign busy_v[i] = (state_q[i] == SLOT_BUSY);
  end
  assign occ_v = wait_v | busy_v;

  dmaq_prio #(.N(DEPTH), .IDX_W(IDX_W)) u_free (
    .req_i   (free_v),
    .found_o (have_free),
    .idx_o   (free_idx)
  );

  dmaq_check #(
    .LADDR_W(LADDR_W), .GADDR_W(GADDR_W), .SIZE_W(SIZE_W), .MAX_BYTES(MAX_BYTES)
  ) u_check (
    .laddr_i (push_laddr),
    .gaddr_i (push_gaddr),
    .size_i  (push_size),
    .ord_i   (push_ord),
    .ok_o    (cmd_ok)
  );

  dmaq_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_i      (store),
    .alloc_idx_i  (free_idx),
    .wait_i       (wait_v),
    .busy_i       (busy_v),
    .tag_i        (tag_q),
    .ord_i        (ord_q),
    .pick_valid_o (pick_valid),
    .pick_idx_o   (pick_idx)
  );

  assign push_ready = have_free;
  assign push_acc   = push_valid && push_ready;
  assign store      = push_acc && cmd_ok;
  assign issue_fire = pick_valid && issue_ready;
  assign cpl_hit    = cpl_valid && (state_q[cpl_id] == SLOT_BUSY);

  // slot state: next-state then register
  always_comb begin
    for (int i = 0; i < DEPTH; i++) state_d[i] = state_q[i];
    if (store)      state_d[free_idx] = SLOT_WAIT;
    if (issue_fire) state_d[pick_idx] = SLOT_BUSY;
    if (cpl_hit)    state_d[cpl_id]   = SLOT_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) state_q[i] <= SLOT_FREE;
      err_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) state_q[i] <= state_d[i];
      err_q <= push_acc && !cmd_ok;
    end
  end

  // payload: written only on accept, no reset needed
  always_ff @(posedge clk) begin
    if (store) begin
      laddr_q[free_idx] <= push_laddr;
      gaddr_q[free_idx] <= push_gaddr;
      size_q[free_idx]  <= push_size;
      tag_q[free_idx]   <= push_tag;
      ord_q[free_idx]   <= push_ord;
      dir_q[free_idx]   <= push_dir;
    end
  end

  assign push_err    = err_q;
  assign issue_valid = pick_valid;
  assign issue_id    = pick_idx;
  assign issue_laddr = laddr_q[pick_idx];
  assign issue_gaddr = gaddr_q[pick_idx];
  assign issue_size  = size_q[pick_idx];
  assign issue_tag   = tag_q[pick_idx];
  assign issue_dir   = dir_q[pick_idx];
  assign done_valid  = cpl_hit;
  assign done_tag    = tag_q[cpl_id];

  assert_slot_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(occ_v) ==
      $countones($past(occ_v)) + int'($past(store)) - int'($past(cpl_hit))));

  assert_err_after_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_err |-> $past(push_valid && push_ready));

  assert_offer_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (state_q[issue_id] == SLOT_WAIT));

  assert_issue_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> (state_q[$past(issue_id)] == SLOT_BUSY));

  assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (state_q[$past(cpl_id)] == SLOT_FREE));

endmodule

// File: tb/tb_dmaq_top.sv
module tb_dmaq_top;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int TAG_W = 5;
  localparam int LA_W  = 18;
  localparam int GA_W  = 32;
  localparam int SZ_W  = 15;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            push_valid, push_ready, push_dir, push_err;
  logic [LA_W-1:0] push_laddr;
  logic [GA_W-1:0] push_gaddr;
  logic [SZ_W-1:0] push_size;
  logic [TAG_W-1:0] push_tag;
  logic [1:0]      push_ord;
  logic            issue_valid, issue_ready, issue_dir;
  logic [3:0]      issue_id;
  logic [LA_W-1:0] issue_laddr;
  logic [GA_W-1:0] issue_gaddr;
  logic [SZ_W-1:0] issue_size;
  logic [TAG_W-1:0] issue_tag;
  logic            cpl_valid, done_valid;
  logic [3:0]      cpl_id;
  logic [TAG_W-1:0] done_tag;

  always #(CLK_P/2) clk = ~clk;

  dmaq_top dut (.*);

  int n_tests = 0;
  int n_fail  = 0;

  // reference model of stored requests
  bit              m_v   [DEPTH];
  bit              m_bsy [DEPTH];
  int              m_seq [DEPTH];
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [1:0]      m_ord [DEPTH];
  logic [LA_W-1:0] m_la  [DEPTH];
  logic [GA_W-1:0] m_ga  [DEPTH];
  logic [SZ_W-1:0] m_sz  [DEPTH];
  logic            m_dir [DEPTH];
  logic [3:0]      m_id  [DEPTH];
  int              seq_n = 0;
  bit              exp_err = 0;
  bit              cexp = 0;
  logic [TAG_W-1:0] ctag = '0;
  int              prev_stall_k = -1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit legal(logic [LA_W-1:0] la, logic [GA_W-1:0] ga, logic [SZ_W-1:0] sz, logic [1:0] od);
    int s = int'(sz);
    int step;
    bit sz_ok = (s == 1 || s == 2 || s == 4 || s == 8) || (s != 0 && s % 16 == 0 && s <= 16384);
    step = (s < 16 && s > 0) ? s : 16;
    return sz_ok && (int'(la) % step == 0) && (ga % step == 0) && (od != 2'd3);
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) if (m_v[i]) c++;
    return c;
  endfunction

  function automatic bit m_elig(int k);
    if (!m_v[k] || m_bsy[k]) return 0;
    for (int j = 0; j < DEPTH; j++) begin
      if (m_v[j] && m_seq[j] < m_seq[k] && m_tag[j] == m_tag[k]) begin
        if (m_ord[j] == 2'd2 && !m_bsy[j]) return 0;
        if (m_ord[k] != 2'd0) return 0;
      end
    end
    return 1;
  endfunction

  function automatic int expect_pick();
    int best = -1;
    for (int k = 0; k < DEPTH; k++)
      if (m_elig(k) && (best < 0 || m_seq[k] < m_seq[best])) best = k;
    return best;
  endfunction

  task automatic set_push(input int la, input int ga, input int sz, input int tg, input bit dr, input int od);
    push_valid = 1'b1; push_laddr = LA_W'(la); push_gaddr = GA_W'(ga);
    push_size = SZ_W'(sz); push_tag = TAG_W'(tg); push_dir = dr; push_ord = 2'(od);
  endtask

  task automatic choose_cpl(input int pct_real, input int pct_bogus);
    int busy_k [$];
    cpl_valid = 1'b0; cexp = 0;
    for (int k = 0; k < DEPTH; k++) if (m_v[k] && m_bsy[k]) busy_k.push_back(k);
    if (busy_k.size() > 0 && ($urandom % 100) < pct_real) begin
      int k = busy_k[$urandom % busy_k.size()];
      cpl_valid = 1'b1; cpl_id = m_id[k]; cexp = 1; ctag = m_tag[k];
    end else if (($urandom % 100) < pct_bogus) begin
      for (int t = 0; t < 8; t++) begin
        logic [3:0] r = 4'($urandom % DEPTH);
        bit used = 0;
        foreach (busy_k[q]) if (m_id[busy_k[q]] == r) used = 1;
        if (!used) begin cpl_valid = 1'b1; cpl_id = r; break; end
      end
    end
  endtask

  task automatic cycle();
    int k;
    string lbl;
    #1;
    chk(push_ready == (m_count() < DEPTH), "R3", push_ready, m_count() < DEPTH);
    k = expect_pick();
    lbl = (k < 0) ? "R7" : (m_ord[k] == 2'd1) ? "R5" : (m_ord[k] == 2'd2) ? "R6" : "R4";
    chk(issue_valid == (k >= 0), lbl, issue_valid, k >= 0);
    if (prev_stall_k >= 0 && m_elig(prev_stall_k))
      chk(issue_valid == 1'b1, "R9", issue_valid, 1);
    if (k >= 0 && issue_valid) begin
      chk({issue_tag, issue_laddr} == {m_tag[k], m_la[k]}, "R7", {issue_tag, issue_laddr}, {m_tag[k], m_la[k]});
      chk(issue_gaddr == m_ga[k], "R7", issue_gaddr, m_ga[k]);
      chk(issue_size == m_sz[k], "R7", issue_size, m_sz[k]);
      chk(issue_dir == m_dir[k], "R10", issue_dir, m_dir[k]);
    end
    chk(push_err == exp_err, "R2", push_err, exp_err);
    chk(done_valid == cexp, "R8", done_valid, cexp);
    if (cexp && done_valid) chk(done_tag == ctag, "R8", done_tag, ctag);
    // model the coming edge
    exp_err = 0;
    if (push_valid && push_ready) begin
      if (legal(push_laddr, push_gaddr, push_size, push_ord)) begin
        for (int i = 0; i < DEPTH; i++) if (!m_v[i]) begin
          m_v[i] = 1; m_bsy[i] = 0; m_seq[i] = seq_n++; m_tag[i] = push_tag;
          m_ord[i] = push_ord; m_la[i] = push_laddr; m_ga[i] = push_gaddr;
          m_sz[i] = push_size; m_dir[i] = push_dir; break;
        end
      end else exp_err = 1;
    end
    prev_stall_k = -1;
    if (k >= 0 && issue_valid) begin
      if (issue_ready) begin m_bsy[k] = 1; m_id[k] = issue_id; end
      else prev_stall_k = k;
    end
    if (cexp) begin
      for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_bsy[i] && m_id[i] == cpl_id) m_v[i] = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    push_valid = 1'b0; cpl_valid = 1'b0; cexp = 0;
  endtask

  function automatic int rand_size();
    case ($urandom % 12)
      0: return 1;   1: return 2;   2: return 4;   3: return 8;
      4: return 16;  5: return 32;  6: return 16 * ($urandom % 1024 + 1);
      7: return 16384; 8: return 48; 9: return 3; 10: return 0;
      default: return ($urandom % 2) ? 16400 : 24;
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL R7: watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; issue_ready = 1'b0; cpl_id = '0;
    push_laddr = '0; push_gaddr = '0; push_size = '0; push_tag = '0; push_dir = 0; push_ord = '0;
    idle_inputs();
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    chk(push_ready == 1 && issue_valid == 0 && done_valid == 0 && push_err == 0, "R1",
        {push_ready, issue_valid, done_valid, push_err}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(push_ready == 1 && issue_valid == 0 && done_valid == 0 && push_err == 0, "R1",
        {push_ready, issue_valid, done_valid, push_err}, 4'b1000);

    // ordering scenario on tag 3 with tag 7 bystander
    issue_ready = 0;
    set_push(16'h100, 32'h1000, 64, 3, 0, 0); cycle();
    set_push(16'h200, 32'h2000, 16, 3, 1, 2); cycle();   // barrier
    set_push(16'h300, 32'h3000, 8, 3, 0, 0);  cycle();   // held behind barrier
    set_push(16'h400, 32'h4000, 4, 7, 1, 1);  cycle();   // fence, other tag
    set_push(16'h500, 32'h5000, 16, 3, 0, 1); cycle();   // fence behind barrier
    push_valid = 0; cycle(); cycle();                    // stall: R9
    issue_ready = 1;
    repeat (4) cycle();
    for (int n = 0; n < 40; n++) begin choose_cpl(50, 0); cycle(); end
    idle_inputs();

    // illegal requests
    issue_ready = 0;
    set_push(16'h101, 32'h0, 4, 1, 0, 0); cycle();   // misaligned local
    set_push(16'h0, 32'h8, 16, 1, 0, 0);  cycle();   // misaligned global
    set_push(16'h0, 32'h0, 0, 1, 0, 0);   cycle();   // zero size
    set_push(16'h0, 32'h0, 16, 1, 0, 3);  cycle();   // reserved ordering
    set_push(16'h0, 32'h0, 16400, 1, 0, 0); cycle(); // too large
    push_valid = 0; cycle(); cycle();

    // fill to capacity
    for (int n = 0; n < 20; n++) begin
      set_push(n * 32, n * 64, 32, n % 3, n % 2, 0); cycle();
    end
    push_valid = 0;
    issue_ready = 1;
    for (int n = 0; n < 80; n++) begin choose_cpl(60, 20); cycle(); end

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int sz = rand_size();
      int la = int'($urandom % (1 << LA_W)) & ~15;
      int ga = int'($urandom) & ~15;
      if ($urandom % 10 == 0) la = la | int'($urandom % 15 + 1);
      if ($urandom % 10 == 0) ga = ga | int'($urandom % 15 + 1);
      if ($urandom % 100 < 60)
        set_push(la, ga, sz, $urandom % 4, $urandom % 2, ($urandom % 16 == 0) ? 3 : $urandom % 3);
      else push_valid = 0;
      issue_ready = ($urandom % 100) < 70;
      choose_cpl(35, 5);
      cycle();
    end

    // drain
    push_valid = 0; issue_ready = 1;
    for (int n = 0; n < 400 && m_count() > 0; n++) begin choose_cpl(60, 0); cycle(); end
    idle_inputs(); cycle();
    chk(m_count() == 0 && push_ready == 1 && issue_valid == 0, "R8", {push_ready, issue_valid}, 2'b10);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule